// File: doc/BRIEF.md
# Multiprocessor-Format Serial Transmitter

This block is an asynchronous serial transmitter with two buffer stages. A host writes a character into a holding register. When the line is free, the transmitter moves the character into a shift register and sends it out as a frame. The frame is a low start bit, then 7 or 8 data bits with the least significant bit first, then one multiprocessor (address/data marker) bit, then one or two high stop bits. Bit timing comes from an external bit-rate tick that is high for one clock cycle per bit period.

Two flags report progress. The empty flag is set when the holding register has handed its character to the shift register, so the host may write the next character. The end flag is set when the stop bits of a frame begin and no further character is waiting. Each flag drives an interrupt request gated by its own enable.

At the last stop bit the transmitter checks the empty flag. If a character is waiting, its start bit follows the stop bits at once, with no mark period in between. Otherwise the line stays at mark (1) until the next character is written.

Top module: `mpx_serial_tx`

## Requirements
- R1: After reset, `txd_o`=1, `tdre_o`=1 and `tend_o`=1.
- R2: A cycle with `wr_i`=1 stores `wr_data_i`. From the next cycle it drives `tdre_o`=0 and `tend_o`=0. A write takes priority over a same-cycle set of either flag.
- R3: On a cycle with `tick_i`=1 and `tdre_o`=0, while the line is idle or the last stop bit is ending, the character is loaded. From the next cycle `tdre_o`=1 and `txd_o`=0 (start bit).
- R4: A frame is 0, then the data bits LSB first, then the multiprocessor bit from `mpb_i`, then stop bits of value 1. `len7_i`=1 selects 7 data bits (`wr_data_i[6:0]`) and 0 selects 8. `two_stop_i`=1 selects two stop bits and 0 selects one.
- R5: Every bit lasts exactly one tick period. `txd_o` changes only in the cycle after a cycle with `tick_i`=1.
- R6: At the tick that starts the first stop bit, if `tdre_o`=1 then `tend_o` becomes 1. While `tend_o`=1, `txd_o`=1.
- R7: If `tdre_o`=0 when the last stop bit ends, the next start bit follows directly, with zero mark periods. If a write arrives during the stop bits after `tend_o` was set, `tend_o` clears and the next frame still follows directly.
- R8: `len7_i`, `two_stop_i` and `mpb_i` are captured at load. Changing them during a frame has no effect on that frame.
- R9: `txi_o` = `tdre_o` AND `tie_i`, and `tei_o` = `tend_o` AND `teie_i`, as levels in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bit-rate tick, one cycle per bit period |
| wr_i | input | 1 | Holding register write strobe |
| wr_data_i | input | DATA_W | Character to send |
| len7_i | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| two_stop_i | input | 1 | 1 selects two stop bits |
| mpb_i | input | 1 | Multiprocessor bit value |
| tie_i | input | 1 | Enable for the data-empty interrupt |
| teie_i | input | 1 | Enable for the transmit-end interrupt |
| txd_o | output | 1 | Serial output, idle high |
| tdre_o | output | 1 | Holding register empty flag |
| tend_o | output | 1 | Transmit end flag |
| txi_o | output | 1 | Data-empty interrupt request |
| tei_o | output | 1 | Transmit-end interrupt request |

## Verification
Flag changes caused by a write appear one clock after the strobe. The bench samples them at the following falling edge. A load, and each new bit, appears one clock after a tick. The monitor therefore samples `txd_o` once per bit period, at the falling edge right after each tick, and rebuilds frames from those samples. A scoreboard queue holds the expected character, format and marker bit for each frame, and whether the frame must follow the previous one with no mark gap. The interrupt outputs are combinational and are checked in the same cycle as their flags.

// File: rtl/mpx_tx_pkg.sv
package mpx_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_MPB   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/mpx_tx_hold.sv
module mpx_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      empty_o <= 1'b1;
    end else begin
      if (wr_i) data_o <= wr_data_i;
      // write wins over a same-cycle hand-off
      if (wr_i)        empty_o <= 1'b0;
      else if (load_i) empty_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mpx_tx_shifter.sv
module mpx_tx_shifter
  import mpx_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              len7_i,
  input  logic              two_stop_i,
  input  logic              mpb_i,
  output logic              load_o,
  output logic              set_end_o,
  output logic              txd_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_FULL  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              stop_cnt_q;
  logic              len7_q, two_q, mpb_q;
  logic              stop_last, data_last;

  assign stop_last = !two_q || stop_cnt_q;
  assign data_last = (bit_cnt_q == (len7_q ? LAST_SHORT : LAST_FULL));
  assign load_o    = tick_i && !empty_i &&
                     ((state_q == ST_IDLE) || ((state_q == ST_STOP) && stop_last));
  assign set_end_o = tick_i && (state_q == ST_MPB) && empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      shift_q    <= '0;
      bit_cnt_q  <= '0;
      stop_cnt_q <= 1'b0;
      len7_q     <= 1'b0;
      two_q      <= 1'b0;
      mpb_q      <= 1'b0;
    end else if (load_o) begin
      state_q    <= ST_START;
      shift_q    <= data_i;
      len7_q     <= len7_i;
      two_q      <= two_stop_i;
      mpb_q      <= mpb_i;
      bit_cnt_q  <= '0;
      stop_cnt_q <= 1'b0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_START: begin
          state_q   <= ST_DATA;
          bit_cnt_q <= '0;
        end
        ST_DATA: begin
          shift_q <= shift_q >> 1;
          if (data_last) state_q <= ST_MPB;
          else           bit_cnt_q <= bit_cnt_q + 1'b1;
        end
        ST_MPB: begin
          state_q    <= ST_STOP;
          stop_cnt_q <= 1'b0;
        end
        ST_STOP: begin
          if (stop_last) state_q <= ST_IDLE;
          else           stop_cnt_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = shift_q[0];
      ST_MPB:   txd_o = mpb_q;
      default:  txd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/mpx_tx_flags.sv
module mpx_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic set_end_i,
  input  logic empty_i,
  input  logic tie_i,
  input  logic teie_i,
  output logic tend_o,
  output logic txi_o,
  output logic tei_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tend_o <= 1'b1;
    else if (wr_i)      tend_o <= 1'b0;
    else if (set_end_i) tend_o <= 1'b1;
  end

  assign txi_o = empty_i & tie_i;
  assign tei_o = tend_o & teie_i;
endmodule

// File: rtl/mpx_serial_tx.sv
module mpx_serial_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              len7_i,
  input  logic              two_stop_i,
  input  logic              mpb_i,
  input  logic              tie_i,
  input  logic              teie_i,
  output logic              txd_o,
  output logic              tdre_o,
  output logic              tend_o,
  output logic              txi_o,
  output logic              tei_o
);
  logic [DATA_W-1:0] hold_data;
  logic              load, set_end;

  mpx_tx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk_i, .rst_ni, .wr_i, .wr_data_i,
    .load_i  (load),
    .data_o  (hold_data),
    .empty_o (tdre_o)
  );

  mpx_tx_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk_i, .rst_ni, .tick_i,
    .empty_i    (tdre_o),
    .data_i     (hold_data),
    .len7_i, .two_stop_i, .mpb_i,
    .load_o     (load),
    .set_end_o  (set_end),
    .txd_o
  );

  mpx_tx_flags i_flags (
    .clk_i, .rst_ni, .wr_i,
    .set_end_i (set_end),
    .empty_i   (tdre_o),
    .tie_i, .teie_i,
    .tend_o, .txi_o, .tei_o
  );
endmodule

// File: rtl/mpx_serial_tx_chk.sv
module mpx_serial_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic wr_i,
  input logic tie_i,
  input logic teie_i,
  input logic txd_o,
  input logic tdre_o,
  input logic tend_o,
  input logic txi_o,
  input logic tei_o
);
  assert_write_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (!tdre_o && !tend_o));

  assert_start_on_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tdre_o) |-> !txd_o);

  assert_bit_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(txd_o));

  assert_end_mark_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tend_o |-> txd_o);

  assert_txi_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tie_i |-> !txi_o);

  assert_tei_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tend_o && teie_i) |-> tei_o);
endmodule

bind mpx_serial_tx mpx_serial_tx_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
  .tie_i(tie_i), .teie_i(teie_i), .txd_o(txd_o), .tdre_o(tdre_o),
  .tend_o(tend_o), .txi_o(txi_o), .tei_o(tei_o)
);

// File: tb/test_mpx_serial_tx.sv
module test_mpx_serial_tx;
  localparam int DATA_W = 8;
  localparam int TDIV   = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic len7 = 1'b0, two = 1'b0, mpb = 1'b0, tie = 1'b1, teie = 1'b1;
  logic txd, tdre, tend, txi, tei;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] data;
    logic       l7, t2, mp, gap0;
  } exp_t;
  exp_t sb_q[$];
  bit in_frame = 0;

  always #5 clk = ~clk;

  mpx_serial_tx #(.DATA_W(DATA_W)) i_mpx_serial_tx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .wr_data_i(wdata),
    .len7_i(len7), .two_stop_i(two), .mpb_i(mpb), .tie_i(tie), .teie_i(teie),
    .txd_o(txd), .tdre_o(tdre), .tend_o(tend), .txi_o(txi), .tei_o(tei)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tick generator
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % TDIV;
      tick = rst_n && (c == 0);
    end
  end

  // driver: write one character and queue its expected frame
  task automatic drive(input logic [7:0] d, input logic l7, input logic t2,
                       input logic mp, input logic gap0);
    exp_t it;
    @(negedge clk);
    wdata = d; len7 = l7; two = t2; mpb = mp; wr = 1'b1;
    it.data = d; it.l7 = l7; it.t2 = t2; it.mp = mp; it.gap0 = gap0;
    sb_q.push_back(it);
    @(negedge clk);
    wr = 1'b0;
    chk(!tdre && !tend, "R2 flags after write", {tdre, tend}, 0);
  endtask

  task automatic wait_flag(input bit want_tend);
    for (int i = 0; i < 2000; i++) begin
      if ((want_tend ? tend : tdre) == 1'b1) return;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 5000; i++) begin
      if (sb_q.size() == 0 && !in_frame) return;
      @(negedge clk);
    end
  endtask

  // monitor: one sample per bit period, right after each tick edge
  initial begin
    int gap = 0, idx = 0, dl = 8, nb = 0;
    logic [15:0] bits = '0;
    exp_t cur;
    forever begin
      @(posedge clk);
      if (tick && rst_n) begin
        @(negedge clk);
        if (!in_frame) begin
          if (txd == 1'b0) begin
            chk(sb_q.size() != 0, "R4 unexpected frame", 0, 1);
            if (sb_q.size() != 0) begin
              cur = sb_q.pop_front();
              if (cur.gap0) chk(gap == 0, "R7 back-to-back gap", gap, 0);
              dl = cur.l7 ? 7 : 8;
              nb = dl + 1 + (cur.t2 ? 2 : 1);
              idx = 0; bits = '0; in_frame = 1;
            end
          end else gap++;
        end else begin
          bits[idx] = txd;
          idx++;
          if (idx == nb) begin
            logic [7:0] got, ex;
            got = bits[7:0]; ex = cur.data;
            if (dl == 7) begin got[7] = 1'b0; ex[7] = 1'b0; end
            chk(got == ex, "R4 R8 data bits", got, ex);
            chk(bits[dl] == cur.mp, "R4 R8 mpb bit", bits[dl], cur.mp);
            chk(bits[dl+1] == 1'b1 && (!cur.t2 || bits[dl+2] == 1'b1),
                "R4 R8 stop bits", bits[dl+2 -: 2], 3);
            in_frame = 0; gap = 0;
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd && tdre && tend, "R1 reset state", {txd, tdre, tend}, 7);
    chk(txi && tei, "R9 irq levels after reset", {txi, tei}, 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd && tdre && tend, "R1 state after release", {txd, tdre, tend}, 7);

    // 8-bit, mpb=1, one stop
    drive(8'hA5, 0, 0, 1, 0);
    chk(!txi && !tei, "R9 irqs low with flags clear", {txi, tei}, 0);
    wait_flag(0);
    chk(txd == 1'b0, "R3 start bit at load", txd, 0);
    chk(txi == 1'b1, "R9 txi with tdre", txi, 1);
    // R5: start bit lasts exactly TDIV cycles
    t0 = 0;
    while (txd == 1'b0 && t0 < 50) begin @(negedge clk); t0++; end
    chk(t0 == TDIV || txd == 1'b1, "R5 start bit length", t0, TDIV);
    wait_flag(1);
    chk(txd == 1'b1 && tei == 1'b1, "R6 end flag with mark", {txd, tei}, 3);
    drain();

    // back-to-back frames: R7
    drive(8'h3C, 0, 1, 0, 0);
    wait_flag(0);
    drive(8'hC3, 0, 0, 1, 1);
    chk(tend == 1'b0, "R7 no end flag while data waits", tend, 0);
    drain();
    wait_flag(1);
    chk(tend == 1'b1, "R6 end flag after last frame", tend, 1);

    // R8: 7-bit, two stops, mpb 0; change inputs after load
    drive(8'hD9, 1, 1, 0, 0);
    wait_flag(0);
    len7 = 1'b0; two = 1'b0; mpb = 1'b1;
    drain();

    // R9 enables off
    tie = 1'b0; teie = 1'b0;
    @(negedge clk);
    chk(!txi && !tei && tdre && tend, "R9 irqs gated off", {txi, tei}, 0);
    tie = 1'b1; teie = 1'b1;

    // R7: write during stop bit after end flag set
    drive(8'h5A, 0, 0, 1, 0);
    wait_flag(1);
    chk(txd == 1'b1, "R6 stop bit high at end flag", txd, 1);
    drive(8'h81, 0, 0, 0, 1);
    chk(tend == 1'b0, "R2 R7 end flag cleared in stop", tend, 0);
    drain();
    drive(8'h7E, 1, 0, 1, 0);
    drain();
    chk(sb_q.size() == 0, "R4 all frames seen", sb_q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule